// File: doc/BRIEF.md
# Memory Error Logging Unit

This block sits beside a memory controller's data path and records the errors that path reports. Each cycle it may receive a pulse for a read parity error, a correctable (single-bit) ECC error, an uncorrectable (multi-bit) ECC error or a refresh overflow. The pulse comes with the address and a bus-status tag of the access that failed, and with a flag that says the address can no longer be trusted. The block does not compute ECC or parity and never stalls or aborts the access. It only updates its own registers, so the failing transfer always finishes normally.

Correctable errors are not flagged one by one. They advance a saturating counter, and a flag is raised only on the event that brings the counter to a programmed trigger value. Every flagged event captures the failing address and tag. An address-invalid bit reads 1 whenever the captured address cannot be relied on. This happens when the access was already lost, when a refresh overflow occurs (which has no address), or when nothing has been captured since reset. Software reads and clears all state through a small register port. Read data is combinational from the register address.

Top module: `mem_err_log`

## Requirements
- R1: After reset, every register reads 0, except the second status register, which reads 0x80 (address-invalid bit set).
- R2: A read parity pulse sets bit 2 of the first status register (offset 1) only when bit 0 of the control register (offset 0) is 1 and the event address lies outside the inclusive window ROM_BASE..ROM_LIMIT. Otherwise it changes no register.
- R3: Each correctable-error pulse adds one to the counter (offset 3). At the all-ones value the counter holds and does not wrap.
- R4: The first-status bit 2 is set, and the address and tag are captured, when an incremented counter value equals a nonzero trigger (offset 4). A trigger of 0 never raises the flag.
- R5: An uncorrectable-error pulse sets bit 3 of the second status register (offset 2) and captures the address and tag.
- R6: A capturing event clears second-status bit 7 and loads the address register (offset 5) and tag register (offset 6). If the address-lost input is high on that event, bit 7 is set instead, and the address and tag keep their old values.
- R7: A refresh-overflow pulse sets second-status bits 0 and 7 and leaves the address and tag unchanged.
- R8: Writing 1 clears first-status bit 2 and second-status bits 0 and 3. A set in the same cycle wins over the clear. Bit 7 ignores writes.
- R9: Writing 0 to the counter clears it and wins over a same-cycle increment. A nonzero write to the counter is ignored. The control bit and the trigger are read/write.
- R10: The register map is: 0 control, 1 status one, 2 status two, 3 counter, 4 trigger, 5 address, 6 tag, 7 reads zero. Unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_rd_parity | input | 1 | Read parity error pulse |
| ev_ecc_single | input | 1 | Correctable ECC error pulse |
| ev_ecc_multi | input | 1 | Uncorrectable ECC error pulse |
| ev_refresh_ovf | input | 1 | Refresh overflow pulse |
| ev_addr_lost | input | 1 | Address of this event is not recoverable |
| ev_addr | input | AW | Address of the failing access |
| ev_tag | input | TW | Bus-status tag of the failing access |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for reg_addr |

## Verification
Directed sequences run parity errors with checking disabled, inside the ROM window and outside it, to separate the two gating conditions. Correctable errors are run with a zero trigger and with a trigger of two, to show that the flag follows the equality and not the count alone. They are also run past 255 events, to separate saturation from wrap-around. Uncorrectable and refresh events are sent with and without the address-lost flag, and with a same-cycle clear, so that capture, invalidation and set-over-clear priority are each seen on the address and status registers. A long random phase then mixes all strobes, window addresses and register writes, and compares a rotating register against a behavioural model every cycle.

// File: rtl/mem_err_log.sv
module mem_err_log #(
  parameter int AW = 32,
  parameter int TW = 4,
  parameter int CW = 8,
  parameter int DW = 32,
  parameter logic [AW-1:0] ROM_BASE  = 32'hFF00_0000,
  parameter logic [AW-1:0] ROM_LIMIT = 32'hFFEF_FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_rd_parity,
  input  logic          ev_ecc_single,
  input  logic          ev_ecc_multi,
  input  logic          ev_refresh_ovf,
  input  logic          ev_addr_lost,
  input  logic [AW-1:0] ev_addr,
  input  logic [TW-1:0] ev_tag,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata
);

  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
  localparam logic [2:0] OFS_CTRL = 3'd0, OFS_ST1 = 3'd1, OFS_ST2 = 3'd2,
                         OFS_CNT = 3'd3, OFS_TRIG = 3'd4, OFS_ADDR = 3'd5,
                         OFS_TAG = 3'd6;

  logic          par_en;
  logic          s1_flag, s2_mbe, s2_ref, addr_inv;
  logic [CW-1:0] cnt, trig;
  logic [AW-1:0] err_addr;
  logic [TW-1:0] err_tag;

  logic          in_rom, par_hit, cnt_inc, trig_hit, capture, lost;
  logic [CW-1:0] cnt_plus, cnt_nxt;
  logic          wr_ctrl, wr_st1, wr_st2, wr_cnt0, wr_trig;

  assign in_rom   = (ev_addr >= ROM_BASE) && (ev_addr <= ROM_LIMIT);
  assign par_hit  = ev_rd_parity && par_en && !in_rom;
  assign cnt_inc  = ev_ecc_single && (cnt != CNT_MAX);
  assign cnt_plus = cnt + 1'b1;
  assign cnt_nxt  = cnt_inc ? cnt_plus : cnt;
  assign trig_hit = cnt_inc && (trig != '0) && (cnt_plus == trig);
  assign capture  = par_hit || trig_hit || ev_ecc_multi;
  assign lost     = ev_refresh_ovf || (capture && ev_addr_lost);

  assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
  assign wr_st1  = reg_wr && (reg_addr == OFS_ST1);
  assign wr_st2  = reg_wr && (reg_addr == OFS_ST2);
  assign wr_cnt0 = reg_wr && (reg_addr == OFS_CNT) && (reg_wdata == '0);
  assign wr_trig = reg_wr && (reg_addr == OFS_TRIG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par_en   <= 1'b0;
      s1_flag  <= 1'b0;
      s2_mbe   <= 1'b0;
      s2_ref   <= 1'b0;
      addr_inv <= 1'b1;
      cnt      <= '0;
      trig     <= '0;
      err_addr <= '0;
      err_tag  <= '0;
    end else begin
      if (wr_ctrl) par_en <= reg_wdata[0];
      if (wr_trig) trig   <= reg_wdata[CW-1:0];

      if (par_hit || trig_hit)      s1_flag <= 1'b1;
      else if (wr_st1 && reg_wdata[2]) s1_flag <= 1'b0;

      if (ev_ecc_multi)             s2_mbe <= 1'b1;
      else if (wr_st2 && reg_wdata[3]) s2_mbe <= 1'b0;

      if (ev_refresh_ovf)           s2_ref <= 1'b1;
      else if (wr_st2 && reg_wdata[0]) s2_ref <= 1'b0;

      if (lost) begin
        addr_inv <= 1'b1;
      end else if (capture) begin
        addr_inv <= 1'b0;
        err_addr <= ev_addr;
        err_tag  <= ev_tag;
      end

      cnt <= wr_cnt0 ? '0 : cnt_nxt;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CTRL: reg_rdata[0] = par_en;
      OFS_ST1:  reg_rdata[2] = s1_flag;
      OFS_ST2:  begin
        reg_rdata[0] = s2_ref;
        reg_rdata[3] = s2_mbe;
        reg_rdata[7] = addr_inv;
      end
      OFS_CNT:  reg_rdata[CW-1:0] = cnt;
      OFS_TRIG: reg_rdata[CW-1:0] = trig;
      OFS_ADDR: reg_rdata[AW-1:0] = err_addr;
      OFS_TAG:  reg_rdata[TW-1:0] = err_tag;
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/mem_err_log_chk.sv
module mem_err_log_chk #(
  parameter int AW = 32,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_rd_parity,
  input logic          ev_ecc_single,
  input logic          ev_ecc_multi,
  input logic          ev_refresh_ovf,
  input logic          reg_wr,
  input logic          par_en,
  input logic          s1_flag,
  input logic          s2_mbe,
  input logic          addr_inv,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] trig,
  input logic [AW-1:0] err_addr
);
  localparam logic [CW-1:0] MAXV = {CW{1'b1}};

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ecc_single && !reg_wr && cnt != MAXV) |=> (cnt == $past(cnt) + 1'b1)); // R3
  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == MAXV && !reg_wr) |=> (cnt == MAXV)); // R3
  AST_PAR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd_parity && !par_en && !ev_ecc_single) |=> !$rose(s1_flag)); // R2
  AST_TRIG_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (trig == '0 && !ev_rd_parity) |=> !$rose(s1_flag)); // R4
  AST_MBE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ecc_multi |=> s2_mbe); // R5
  AST_REF_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    ev_refresh_ovf |=> (addr_inv && $stable(err_addr))); // R7
endmodule

bind mem_err_log mem_err_log_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_rd_parity(ev_rd_parity),
  .ev_ecc_single(ev_ecc_single), .ev_ecc_multi(ev_ecc_multi),
  .ev_refresh_ovf(ev_refresh_ovf), .reg_wr(reg_wr), .par_en(par_en),
  .s1_flag(s1_flag), .s2_mbe(s2_mbe), .addr_inv(addr_inv),
  .cnt(cnt), .trig(trig), .err_addr(err_addr)
);

// File: tb/sim_mem_err_log.sv
module sim_mem_err_log;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ROM_B = 32'hFF00_0000;
  localparam logic [31:0] ROM_L = 32'hFFEF_FFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_rd_parity = 0, ev_ecc_single = 0, ev_ecc_multi = 0;
  logic ev_refresh_ovf = 0, ev_addr_lost = 0;
  logic [31:0] ev_addr = '0;
  logic [3:0]  ev_tag = '0;
  logic        reg_wr = 0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int errs = 0, checks = 0;
  logic m_par = 0, m_pf = 0, m_mf = 0, m_rf = 0, m_inv = 1;
  int m_cnt = 0, m_trig = 0;
  logic [31:0] m_addr = '0;
  logic [3:0]  m_tag = '0;

  mem_err_log u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    logic [31:0] v = '0;
    case (a)
      3'd0: v[0] = m_par;
      3'd1: v[2] = m_pf;
      3'd2: begin v[0] = m_rf; v[3] = m_mf; v[7] = m_inv; end
      3'd3: v = 32'(m_cnt);
      3'd4: v = 32'(m_trig);
      3'd5: v = m_addr;
      3'd6: v[3:0] = m_tag;
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic chk_val(input logic [2:0] a, input logic [31:0] e, input string req);
    reg_addr = a; #1;
    checks++;
    if (reg_rdata !== e) begin
      errs++;
      $display("FAIL %s reg %0d: got %h expected %h", req, a, reg_rdata, e);
    end
  endtask

  task automatic chk(input logic [2:0] a, input string req);
    chk_val(a, exp_rd(a), req);
  endtask

  task automatic tick();
    logic rom, ph, inc, th, cap, lost;
    int cn;
    rom = (ev_addr >= ROM_B) && (ev_addr <= ROM_L);
    ph = ev_rd_parity && m_par && !rom;
    inc = ev_ecc_single && (m_cnt != 255);
    cn = inc ? m_cnt + 1 : m_cnt;
    th = inc && (m_trig != 0) && (cn == m_trig);
    cap = ph || th || ev_ecc_multi;
    lost = ev_refresh_ovf || (cap && ev_addr_lost);
    if (reg_wr && reg_addr == 1 && reg_wdata[2]) m_pf = 0;
    if (ph || th) m_pf = 1;
    if (reg_wr && reg_addr == 2 && reg_wdata[3]) m_mf = 0;
    if (ev_ecc_multi) m_mf = 1;
    if (reg_wr && reg_addr == 2 && reg_wdata[0]) m_rf = 0;
    if (ev_refresh_ovf) m_rf = 1;
    if (lost) m_inv = 1;
    else if (cap) begin m_inv = 0; m_addr = ev_addr; m_tag = ev_tag; end
    m_cnt = (reg_wr && reg_addr == 3 && reg_wdata == 0) ? 0 : cn;
    if (reg_wr && reg_addr == 0) m_par = reg_wdata[0];
    if (reg_wr && reg_addr == 4) m_trig = int'(reg_wdata[7:0]);
    @(posedge clk); @(negedge clk);
    ev_rd_parity = 0; ev_ecc_single = 0; ev_ecc_multi = 0;
    ev_refresh_ovf = 0; ev_addr_lost = 0; reg_wr = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; tick();
  endtask

  task automatic ev(input int kind, input logic [31:0] a, input logic [3:0] t, input logic lst);
    ev_addr = a; ev_tag = t; ev_addr_lost = lst;
    case (kind)
      0: ev_rd_parity = 1;
      1: ev_ecc_single = 1;
      2: ev_ecc_multi = 1;
      default: ev_refresh_ovf = 1;
    endcase
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    chk_val(0, 0, "R1"); chk_val(1, 0, "R1"); chk_val(2, 32'h80, "R1");
    chk_val(3, 0, "R1"); chk_val(4, 0, "R1"); chk_val(5, 0, "R1"); chk_val(6, 0, "R1");
    // R2 parity gating
    ev(0, 32'h0000_1000, 4'h3, 0);
    chk_val(1, 0, "R2"); chk_val(2, 32'h80, "R2");
    wr(0, 1); chk_val(0, 1, "R9");
    ev(0, 32'hFF10_0000, 4'h3, 0);
    chk_val(1, 0, "R2"); chk_val(5, 0, "R2");
    ev(0, 32'h0000_1000, 4'h3, 0);
    chk_val(1, 32'h4, "R2"); chk_val(5, 32'h0000_1000, "R6");
    chk_val(6, 3, "R6"); chk_val(2, 0, "R6");
    // R8 clear
    wr(1, 32'h4); chk_val(1, 0, "R8");
    // R4 zero trigger, R3 increments
    repeat (3) ev(1, 32'h2000, 4'h1, 0);
    chk_val(3, 3, "R3"); chk_val(1, 0, "R4");
    // R9 counter writes
    wr(3, 32'h5); chk_val(3, 3, "R9");
    ev_ecc_single = 1; wr(3, 0); chk_val(3, 0, "R9");
    // R4 trigger of two
    wr(4, 2); chk_val(4, 2, "R9");
    ev(1, 32'h3000, 4'h5, 0);
    chk_val(1, 0, "R4"); chk_val(5, 32'h0000_1000, "R4");
    ev(1, 32'h4000, 4'h6, 0);
    chk_val(1, 32'h4, "R4"); chk_val(5, 32'h4000, "R4"); chk_val(6, 6, "R4");
    // R5/R6 multi-bit with lost address
    ev(2, 32'h5000, 4'h7, 1);
    chk_val(2, 32'h88, "R6"); chk_val(5, 32'h4000, "R6");
    ev(2, 32'h6000, 4'h8, 0);
    chk_val(2, 32'h08, "R5"); chk_val(5, 32'h6000, "R5"); chk_val(6, 8, "R5");
    // R8 set wins over clear, bit 7 ignores writes
    ev_ecc_multi = 1; wr(2, 32'hFF); chk_val(2, 32'h08, "R8");
    wr(2, 32'h88); chk_val(2, 32'h0, "R8");
    // R7 refresh overflow
    ev(3, 32'h7000, 4'h9, 0);
    chk_val(2, 32'h81, "R7"); chk_val(5, 32'h6000, "R7"); chk_val(6, 8, "R7");
    // R3 saturation
    wr(4, 0); wr(3, 0);
    repeat (260) ev(1, 32'h8000, 4'h2, 0);
    chk_val(3, 255, "R3");
    chk_val(7, 0, "R10");
    // R10 random mix against model
    for (int i = 0; i < 3000; i++) begin
      ev_rd_parity   = ($urandom % 4) == 0;
      ev_ecc_single  = ($urandom % 2) == 0;
      ev_ecc_multi   = ($urandom % 8) == 0;
      ev_refresh_ovf = ($urandom % 16) == 0;
      ev_addr_lost   = ($urandom % 6) == 0;
      ev_addr = (($urandom % 4) == 0) ? (ROM_B + ($urandom % 32'h0100_0000)) : $urandom;
      ev_tag = 4'($urandom);
      reg_wr = ($urandom % 6) == 0;
      reg_addr = 3'($urandom);
      reg_wdata = (($urandom % 3) == 0) ? 32'h0 : (($urandom % 2) ? ($urandom % 6) : $urandom);
      tick();
      chk(3'(i % 8), "R10");
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule